// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block is the bus glue between an 8-bit processor and what sits behind its address space. The 256 addresses split into four 64-byte regions. The two most significant address bits pick the region. The lower three regions belong to a code/data RAM, which the block contains as a synchronous array. The topmost region belongs to a small I/O port: a bank of input switches and an output LED register.

A write is routed only to the device that owns the addressed region, so a store into the I/O range never reaches the RAM. A store into RAM never touches the LEDs. On a read, the block returns either the RAM word or the switch value. Both paths have one cycle of latency. The return multiplexer selects with the region bits registered at the time of the read. The switch inputs are asynchronous, so they pass through a two-stage synchronizer before they can be read.

Top module: `mmio_bus_glue`

## Requirements
- R1: While reset is high at a clock edge, and after that edge, `leds` is 0 and `readdata` is 0.
- R2: A write with `memwrite` high to an address from 0x00 to 0xBF stores `writedata` in RAM at that address. A read with `memread` high at a clock edge to such an address drives that word on `readdata` after the edge.
- R3: A write with `memwrite` high to an address from 0xC0 to 0xFF loads `writedata` into `leds` at that edge and leaves every RAM word unchanged.
- R4: `leds` changes only on a clock edge where `memwrite` is high and address bits [7:6] are 2'b11. This includes RAM writes, which leave `leds` unchanged.
- R5: A read with `memread` high to an address from 0xC0 to 0xFF returns the switch value sampled two clock edges earlier. A change on `switches` first appears for a read issued at the third edge after the change.
- R6: When `memread` is low at an edge, `readdata` keeps its previous value, whatever the address.
- R7: A read and a write to the same RAM address at the same edge return the word stored before that write.
- R8: Writes presented while reset is high change neither RAM nor `leds`. RAM contents survive a reset.
- R9: Address 0xBF behaves as RAM and address 0xC0 behaves as I/O.
- R10: With `memwrite` low, an address in the I/O range does not alter `leds`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| reset | input | 1 | Synchronous active-high reset |
| adr | input | 8 | Byte address from the processor |
| writedata | input | 8 | Store data |
| memwrite | input | 1 | Store strobe for the current cycle |
| memread | input | 1 | Load strobe for the current cycle |
| readdata | output | 8 | Load data, valid the cycle after the load strobe |
| switches | input | 8 | Asynchronous switch inputs |
| leds | output | 8 | LED output register |

## Verification
The bench builds the block with its default parameters: an 8-bit address, two region-select bits, one I/O region and two synchronizer stages. Every one of the 256 addresses is therefore reachable, including both edges of the RAM-to-I/O boundary at 0xBF and 0xC0. Because the synchronizer depth is small, the exact edge at which a switch change becomes readable can be probed read by read.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  // Which device answered the most recent load.
  typedef enum logic {
    TGT_MEM = 1'b0,
    TGT_IO  = 1'b1
  } target_e;
endpackage

// File: rtl/mmio_region_dec.sv
module mmio_region_dec
  import mmio_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int REGION_BITS = 2,
  parameter int IO_REGIONS  = 1
) (
  input  logic              reset,
  input  logic [ADDR_W-1:0] adr,
  input  logic              memwrite,
  input  logic              memread,
  output target_e           target,
  output logic              ram_we,
  output logic              ram_re,
  output logic              io_we,
  output logic              io_re
);
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam int IO_FIRST    = NUM_REGIONS - IO_REGIONS;

  logic [REGION_BITS-1:0] sel;
  logic [NUM_REGIONS-1:0] hit;
  logic [NUM_REGIONS-1:0] io_owned;

  assign sel = adr[ADDR_W-1 -: REGION_BITS];

  // One hit line per region; ownership fixed by index.
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign hit[g]      = (sel == g[REGION_BITS-1:0]);
    assign io_owned[g] = (g >= IO_FIRST);
  end

  logic in_io;
  assign in_io  = |(hit & io_owned);
  assign target = in_io ? TGT_IO : TGT_MEM;

  // Strobes are routed to exactly one owner and suppressed in reset.
  assign ram_we = memwrite & ~in_io & ~reset;
  assign io_we  = memwrite &  in_io & ~reset;
  assign ram_re = memread  & ~in_io & ~reset;
  assign io_re  = memread  &  in_io & ~reset;
endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 192
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];

  // Array write kept free of reset so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Read-first output register with synchronous reset.
  always_ff @(posedge clk) begin
    if (reset)   rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/mmio_io_port.sv
module mmio_io_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] switches,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] leds
);
  logic [DATA_W-1:0] sync_r [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (reset) sync_r[0] <= '0;
        else       sync_r[0] <= switches;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (reset) sync_r[s] <= '0;
        else       sync_r[s] <= sync_r[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reset) begin
      leds  <= '0;
      rdata <= '0;
    end else begin
      if (we) leds  <= wdata;
      if (re) rdata <= sync_r[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/mmio_bus_glue.sv
module mmio_bus_glue
  import mmio_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int REGION_BITS = 2,
  parameter int IO_REGIONS  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              reset,
  input  logic [ADDR_W-1:0] adr,
  input  logic [DATA_W-1:0] writedata,
  input  logic              memwrite,
  input  logic              memread,
  output logic [DATA_W-1:0] readdata,
  input  logic [DATA_W-1:0] switches,
  output logic [DATA_W-1:0] leds
);
  localparam int REGION_SIZE = 1 << (ADDR_W - REGION_BITS);
  localparam int RAM_DEPTH   = ((1 << REGION_BITS) - IO_REGIONS) * REGION_SIZE;
  localparam int RAM_AW      = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

  target_e           target;
  target_e           target_q;
  logic              ram_we, ram_re, io_we, io_re;
  logic [DATA_W-1:0] ram_q, io_q;

  mmio_region_dec #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .IO_REGIONS(IO_REGIONS)
  ) u_dec (
    .reset(reset), .adr(adr), .memwrite(memwrite), .memread(memread),
    .target(target), .ram_we(ram_we), .ram_re(ram_re),
    .io_we(io_we), .io_re(io_re)
  );

  mmio_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .reset(reset), .we(ram_we), .re(ram_re),
    .addr(adr[RAM_AW-1:0]), .wdata(writedata), .rdata(ram_q)
  );

  mmio_io_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_io (
    .clk(clk), .reset(reset), .we(io_we), .re(io_re),
    .wdata(writedata), .switches(switches), .rdata(io_q), .leds(leds)
  );

  // Owner of the last load, captured alongside the data registers.
  always_ff @(posedge clk) begin
    if (reset)        target_q <= TGT_MEM;
    else if (memread) target_q <= target;
  end

  assign readdata = (target_q == TGT_IO) ? io_q : ram_q;
endmodule

// File: rtl/mmio_glue_chk.sv
module mmio_glue_chk #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int REGION_BITS = 2
) (
  input logic              clk,
  input logic              reset,
  input logic [ADDR_W-1:0] adr,
  input logic [DATA_W-1:0] writedata,
  input logic              memwrite,
  input logic              memread,
  input logic [DATA_W-1:0] readdata,
  input logic [DATA_W-1:0] leds,
  input logic              ram_we,
  input logic              io_we
);
  logic top_io;
  assign top_io = (adr[ADDR_W-1 -: REGION_BITS] == {REGION_BITS{1'b1}});

  AST_RESET_CLEARS: assert property (@(posedge clk)
    reset |=> (leds == '0 && readdata == '0)); // R1

  AST_IO_WRITE_LOADS: assert property (@(posedge clk) disable iff (reset)
    (memwrite && top_io) |=> (leds == $past(writedata))); // R3

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (reset)
    !(memwrite && top_io) |=> $stable(leds)); // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (reset)
    !memread |=> $stable(readdata)); // R6

  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (reset)
    $onehot0({ram_we, io_we})); // R3

  AST_RAM_WE_RANGE: assert property (@(posedge clk) disable iff (reset)
    ram_we |-> !top_io); // R3
endmodule

bind mmio_bus_glue mmio_glue_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_BITS(REGION_BITS)
) u_chk (
  .clk(clk), .reset(reset), .adr(adr), .writedata(writedata),
  .memwrite(memwrite), .memread(memread), .readdata(readdata),
  .leds(leds), .ram_we(ram_we), .io_we(io_we)
);

// File: tb/tb_mmio_bus_glue.sv
`timescale 1ns/1ps
module tb_mmio_bus_glue;
  logic       clk = 1'b0;
  logic       reset = 1'b1;
  logic [7:0] adr = '0, writedata = '0, switches = '0;
  logic       memwrite = 1'b0, memread = 1'b0;
  logic [7:0] readdata, leds;

  always #2 clk = ~clk;

  mmio_bus_glue dut (
    .clk(clk), .reset(reset), .adr(adr), .writedata(writedata),
    .memwrite(memwrite), .memread(memread), .readdata(readdata),
    .switches(switches), .leds(leds)
  );

  // Behavioural reference model
  int    mem_m [256];
  bit    mem_ok [256];
  int    exp_leds = 0, exp_rd = 0;
  bit    rd_known = 1'b1;
  int    swq [$];
  string tag = "R1";
  int    total = 0, bad = 0, cycles = 0;
  bit    done = 1'b0;

  initial begin
    swq.push_back(0);
    swq.push_back(0);
  end

  always @(posedge clk) begin
    if (reset) begin
      exp_leds = 0; exp_rd = 0; rd_known = 1'b1;
      swq.delete(); swq.push_back(0); swq.push_back(0);
    end else begin
      if (memread) begin
        if (adr >= 8'hC0) begin exp_rd = swq[0]; rd_known = 1'b1; end
        else begin exp_rd = mem_m[adr]; rd_known = mem_ok[adr]; end
      end
      if (memwrite) begin
        if (adr >= 8'hC0) exp_leds = writedata;
        else begin mem_m[adr] = writedata; mem_ok[adr] = 1'b1; end
      end
      swq.push_back(int'(switches));
      void'(swq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (int'(leds) != exp_leds) begin
        bad++;
        $display("FAIL %s leds actual=%0h expected=%0h", tag, leds, exp_leds);
      end
      if (rd_known) begin
        total++;
        if (int'(readdata) != exp_rd) begin
          bad++;
          $display("FAIL %s readdata actual=%0h expected=%0h", tag, readdata, exp_rd);
        end
      end
    end
  end

  task automatic idle(input int n);
    memwrite = 0; memread = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int a, input int d);
    adr = a[7:0]; writedata = d[7:0]; memwrite = 1; memread = 0;
    @(negedge clk);
    memwrite = 0;
  endtask

  task automatic get(input int a);
    adr = a[7:0]; memread = 1; memwrite = 0;
    @(negedge clk);
    memread = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 and R8: writes presented during reset are dropped
    tag = "R8";
    adr = 8'hC0; writedata = 8'hAA; memwrite = 1;
    repeat (4) @(negedge clk);
    reset = 0; memwrite = 0;
    tag = "R1";
    idle(2);

    // R2: fill all of RAM, then read back
    tag = "R2";
    for (int a = 0; a < 192; a++) put(a, (a * 7 + 3) & 8'hFF);

    // R3: I/O stores load the LEDs
    tag = "R3";
    put(8'hC0, 8'h5A); idle(1);
    put(8'hFF, 8'hC3); idle(1);
    put(8'hD5, 8'h81); idle(1);

    tag = "R2";
    for (int a = 0; a < 192; a++) get(a);

    // R4: RAM stores leave LEDs alone
    tag = "R4";
    put(8'h10, 8'hEE); put(8'h7F, 8'h11); get(8'h10); idle(1);

    // R5: switch change visible at the third edge
    tag = "R5";
    switches = 8'h3C;
    get(8'hC1); get(8'hE0); get(8'hC8); get(8'hFF); idle(1);
    switches = 8'hA5; idle(3); get(8'hF0); idle(1);

    // R6: hold read data while memread is low
    tag = "R6";
    adr = 8'h20; idle(2); adr = 8'hC4; idle(2); adr = 8'h00; idle(1);

    // R7: same-edge read and write return the old word
    tag = "R7";
    adr = 8'h20; writedata = 8'h99; memwrite = 1; memread = 1;
    @(negedge clk);
    memwrite = 0; memread = 0;
    get(8'h20); idle(1);

    // R9: boundary addresses
    tag = "R9";
    put(8'hBF, 8'h42); get(8'hBF); get(8'hC0);
    put(8'hC0, 8'h24); get(8'hBF); idle(1);

    // R10: address in I/O range without the store strobe
    tag = "R10";
    adr = 8'hC0; writedata = 8'hFF; idle(3);

    // R8: reset mid-run with pending stores, RAM preserved
    tag = "R8";
    reset = 1; adr = 8'h05; writedata = 8'h00; memwrite = 1;
    @(negedge clk);
    adr = 8'hC2; @(negedge clk);
    memwrite = 0; reset = 0;
    idle(1);
    get(8'h05); get(8'h20); idle(2);

    finish_run();
  end
endmodule